// File: doc/BRIEF.md
# Packed SIMD Unpack Unit

This unit takes two 64-bit packed operands, A and B, and builds a 64-bit result from the lanes of one 32-bit half of each operand. A half select picks the half, low or high. The same half select applies to every operation. An element size control picks bytes, halfwords or words. A mode control picks one of three operations:

- interleave the selected elements of A and B;
- widen the selected elements of A with zero fill;
- widen the selected elements of A with sign fill.

Along with the result, the unit produces a 32-bit flag word. It holds a negative bit and a zero bit for every lane of the result. Where those bits sit depends on the lane size of the result, not on the size of the source elements. The unit registers every operation it accepts. The result, the flags and an error bit appear together with a one-cycle valid strobe. If the size and mode controls form an illegal combination, the result and the flags are zero and the error bit is set.

Top module: `simd_unpack_unit`

## Requirements
- R1: With `selHigh` at 0 the source elements are taken from bits 31:0 of each operand. With `selHigh` at 1 they are taken from bits 63:32.
- R2: Byte interleave (`elemSize`=0, `mode`=0) places source byte k of A at result byte 2k and source byte k of B at result byte 2k+1, for k from 0 to 3. The flags use byte lanes.
- R3: Halfword interleave (`elemSize`=1, `mode`=0) gives result halfwords A0, B0, A1, B1, from least significant to most significant, and the flags use halfword lanes. Word interleave (`elemSize`=2, `mode`=0) gives A in the low word and B in the high word, and the flags use word lanes.
- R4: Byte widening (`elemSize`=0) places each of the four selected bytes of A in a 16-bit lane. The fill is zeros when `mode`=1 and copies of the byte's top bit when `mode`=2. The flags use halfword lanes.
- R5: Halfword widening (`elemSize`=1) gives two 32-bit lanes, with flags in word lanes. Word widening (`elemSize`=2) gives one 64-bit value, with the 64-bit flag layout. In both cases the fill is zero for `mode`=1 and the sign for `mode`=2.
- R6: The N bit is the top bit of its result lane. The Z bit is set when its lane is all zero. The positions are:
  - byte lane k: N at bit 4k+3, Z at bit 4k+2;
  - halfword lane k: N at 8k+7, Z at 8k+6;
  - word lane k: N at 16k+15, Z at 16k+14;
  - 64-bit result: N at bit 31, Z at bit 30.
- R7: Every flag bit that the current result lane size does not use is zero.
- R8: An `elemSize` of 3 or a `mode` of 3 is illegal. An illegal operation gives a result of zero and flags of zero, and sets `err`. A legal operation clears `err`.
- R9: `outValid` is high for exactly the cycle after each cycle in which `inValid` is high. While `inValid` is low, `result`, `flags` and `err` hold their values.
- R10: After reset, `outValid`, `result`, `flags` and `err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Accept the operation on the inputs this cycle |
| opA | input | 64 | Packed operand A |
| opB | input | 64 | Packed operand B (used only by interleave) |
| selHigh | input | 1 | 0: use bits 31:0; 1: use bits 63:32 |
| elemSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| mode | input | 2 | 0 interleave, 1 zero widen, 2 sign widen, 3 illegal |
| outValid | output | 1 | Result strobe, one cycle |
| result | output | 64 | Unpacked result |
| flags | output | 32 | Per-lane N/Z flag word |
| err | output | 1 | Last accepted operation was illegal |

## Verification
There is one register stage between the inputs and the outputs. Every output is due at the first rising edge after `inValid` is sampled high. The bench drives the inputs on the falling edge and checks result, flags, err and the strobe on the next falling edge, which is half a cycle after they have settled. For the hold property, the bench changes the operands with `inValid` low and checks one falling edge later that nothing has moved.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

  // Lane size of the result, which selects the flag layout.
  typedef enum logic [1:0] {
    LANE8  = 2'd0,
    LANE16 = 2'd1,
    LANE32 = 2'd2,
    LANE64 = 2'd3
  } laneSize_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic      load;
    logic      illegal;
    logic      interleave;
    logic      signFill;
    logic [1:0] srcSize;
    laneSize_t resLane;
  } unpackCtrl_t;

endpackage

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import unpack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  elemSize,
  input  logic [1:0]  mode,
  output unpackCtrl_t ctrl,
  output logic        outValid,
  output logic        err
);

  logic isIllegal;

  always_comb begin
    isIllegal       = (elemSize == 2'd3) || (mode == 2'd3);
    ctrl.load       = inValid;
    ctrl.illegal    = isIllegal;
    ctrl.interleave = (mode == 2'd0);
    ctrl.signFill   = (mode == 2'd2);
    ctrl.srcSize    = elemSize;
    if (mode == 2'd0) ctrl.resLane = laneSize_t'(elemSize);
    else              ctrl.resLane = laneSize_t'(elemSize + 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      err      <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) err <= isIllegal;
    end
  end

  // R9: strobe follows an accepted operation by one cycle
  assert_strobe_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_strobe_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/unpack_datapath.sv
module unpack_datapath
  import unpack_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  unpackCtrl_t       ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              selHigh,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W/2-1:0] flags
);

  localparam int HALF_W = DATA_W / 2;
  localparam int FLAG_W = DATA_W / 2;
  localparam int NBYTE  = HALF_W / 8;
  localparam int NHALF  = HALF_W / 16;

  logic [HALF_W-1:0] srcA, srcB;
  assign srcA = selHigh ? opA[DATA_W-1:HALF_W] : opA[HALF_W-1:0];
  assign srcB = selHigh ? opB[DATA_W-1:HALF_W] : opB[HALF_W-1:0];

  logic [DATA_W-1:0] ilvByte, ilvHalf, ilvWord, extByte, extHalf, extWord;

  // Interleave and widen, per source lane
  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    assign ilvByte[16*k +: 8]     = srcA[8*k +: 8];
    assign ilvByte[16*k + 8 +: 8] = srcB[8*k +: 8];
    assign extByte[16*k +: 16]    = {{8{ctrl.signFill & srcA[8*k+7]}}, srcA[8*k +: 8]};
  end
  for (genvar k = 0; k < NHALF; k++) begin : g_half
    assign ilvHalf[32*k +: 16]      = srcA[16*k +: 16];
    assign ilvHalf[32*k + 16 +: 16] = srcB[16*k +: 16];
    assign extHalf[32*k +: 32]      = {{16{ctrl.signFill & srcA[16*k+15]}}, srcA[16*k +: 16]};
  end
  assign ilvWord = {srcB, srcA};
  assign extWord = {{HALF_W{ctrl.signFill & srcA[HALF_W-1]}}, srcA};

  logic [DATA_W-1:0] nextRes;
  always_comb begin
    nextRes = '0;
    if (!ctrl.illegal) begin
      unique case (ctrl.srcSize)
        2'd0:    nextRes = ctrl.interleave ? ilvByte : extByte;
        2'd1:    nextRes = ctrl.interleave ? ilvHalf : extHalf;
        default: nextRes = ctrl.interleave ? ilvWord : extWord;
      endcase
    end
  end

  // Flag words for each result lane size
  logic [FLAG_W-1:0] fl8, fl16, fl32, fl64;
  for (genvar k = 0; k < DATA_W/8; k++) begin : g_f8
    assign fl8[4*k+3]      = nextRes[8*k+7];
    assign fl8[4*k+2]      = ~|nextRes[8*k +: 8];
    assign fl8[4*k +: 2]   = 2'b00;
  end
  for (genvar k = 0; k < DATA_W/16; k++) begin : g_f16
    assign fl16[8*k+7]     = nextRes[16*k+15];
    assign fl16[8*k+6]     = ~|nextRes[16*k +: 16];
    assign fl16[8*k +: 6]  = '0;
  end
  for (genvar k = 0; k < DATA_W/32; k++) begin : g_f32
    assign fl32[16*k+15]   = nextRes[32*k+31];
    assign fl32[16*k+14]   = ~|nextRes[32*k +: 32];
    assign fl32[16*k +: 14] = '0;
  end
  assign fl64 = {nextRes[DATA_W-1], ~|nextRes, {(FLAG_W-2){1'b0}}};

  logic [FLAG_W-1:0] nextFlags;
  always_comb begin
    nextFlags = '0;
    if (!ctrl.illegal) begin
      unique case (ctrl.resLane)
        LANE8:   nextFlags = fl8;
        LANE16:  nextFlags = fl16;
        LANE32:  nextFlags = fl32;
        default: nextFlags = fl64;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else if (ctrl.load) begin
      result <= nextRes;
      flags  <= nextFlags;
    end
  end

  // R9: outputs hold when no operation is accepted
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(result) && $stable(flags)));
  // R6: 64-bit zero flag tracks the registered result
  assert_dword_zflag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.illegal && ctrl.resLane == LANE64) |=> (flags[FLAG_W-2] == (result == '0)));
  // R7: 64-bit layout leaves the lower flag bits clear
  assert_dword_unused_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.resLane == LANE64) |=> (flags[FLAG_W-3:0] == '0));

endmodule

// File: rtl/simd_unpack_unit.sv
module simd_unpack_unit
  import unpack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic        selHigh,
  input  logic [1:0]  elemSize,
  input  logic [1:0]  mode,
  output logic        outValid,
  output logic [63:0] result,
  output logic [31:0] flags,
  output logic        err
);

  unpackCtrl_t ctrl;

  unpack_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .elemSize(elemSize), .mode(mode),
    .ctrl(ctrl), .outValid(outValid), .err(err)
  );

  unpack_datapath #(.DATA_W(64)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB), .selHigh(selHigh),
    .result(result), .flags(flags)
  );

  // R8: an error report always comes with an all-zero result and flag word
  assert_err_zeroes_R8: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (result == 64'd0 && flags == 32'd0));

endmodule

// File: tb/tb_simd_unpack_unit.sv
module tb_simd_unpack_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic        selHigh = 1'b0;
  logic [1:0]  elemSize = '0, mode = '0;
  logic        outValid, err;
  logic [63:0] result;
  logic [31:0] flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  simd_unpack_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .selHigh(selHigh), .elemSize(elemSize), .mode(mode),
    .outValid(outValid), .result(result), .flags(flags), .err(err)
  );

  function automatic logic [63:0] expRes(logic [63:0] a, logic [63:0] b, logic hi,
                                         logic [1:0] sz, logic [1:0] md);
    logic [31:0] ha, hb;
    logic [63:0] r;
    logic sg;
    ha = hi ? a[63:32] : a[31:0];
    hb = hi ? b[63:32] : b[31:0];
    sg = (md == 2'd2);
    r = '0;
    if (sz == 2'd3 || md == 2'd3) return '0;
    if (md == 2'd0) begin
      case (sz)
        2'd0: for (int k = 0; k < 4; k++) begin
                r[16*k +: 8] = ha[8*k +: 8];
                r[16*k+8 +: 8] = hb[8*k +: 8];
              end
        2'd1: r = {hb[31:16], ha[31:16], hb[15:0], ha[15:0]};
        default: r = {hb, ha};
      endcase
    end else begin
      case (sz)
        2'd0: for (int k = 0; k < 4; k++)
                r[16*k +: 16] = {{8{sg & ha[8*k+7]}}, ha[8*k +: 8]};
        2'd1: for (int k = 0; k < 2; k++)
                r[32*k +: 32] = {{16{sg & ha[16*k+15]}}, ha[16*k +: 16]};
        default: r = {{32{sg & ha[31]}}, ha};
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] expFlags(logic [63:0] r, logic [1:0] sz, logic [1:0] md);
    int lb;
    int stride;
    logic [63:0] lane;
    logic [31:0] f;
    f = '0;
    if (sz == 2'd3 || md == 2'd3) return '0;
    lb = 8 << (sz + ((md == 2'd0) ? 0 : 1));
    if (lb == 64) begin
      f[31] = r[63];
      f[30] = (r == 64'd0);
      return f;
    end
    stride = lb / 2;
    for (int k = 0; k < 64 / lb; k++) begin
      lane = (r >> (k * lb)) & ((64'd1 << lb) - 64'd1);
      f[stride*k + stride - 1] = lane[lb-1];
      f[stride*k + stride - 2] = (lane == 64'd0);
    end
    return f;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic runOp(string req, logic [63:0] a, logic [63:0] b, logic hi,
                       logic [1:0] sz, logic [1:0] md);
    logic [63:0] er;
    opA = a; opB = b; selHigh = hi; elemSize = sz; mode = md; inValid = 1'b1;
    er = expRes(a, b, hi, sz, md);
    @(negedge clk);
    inValid = 1'b0;
    check({req, " result"}, result, er);
    check({req, " flags R6 R7"}, {32'd0, flags}, {32'd0, expFlags(er, sz, md)});
    check({req, " err R8"}, {63'd0, err}, {63'd0, (sz == 2'd3 || md == 2'd3)});
    check({req, " strobe R9"}, {63'd0, outValid}, 64'd1);
  endtask

  task automatic holdCheck();
    logic [63:0] r0;
    logic [31:0] f0;
    logic e0;
    r0 = result; f0 = flags; e0 = err;
    opA = ~opA; opB = ~opB; elemSize = 2'd3; selHigh = ~selHigh;
    @(negedge clk);
    check("R9 hold result", result, r0);
    check("R9 hold flags", {32'd0, flags}, {32'd0, f0});
    check("R9 hold err", {63'd0, err}, {63'd0, e0});
    check("R9 strobe low", {63'd0, outValid}, 64'd0);
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R10 strobe", {63'd0, outValid}, 64'd0);
    check("R10 result", result, 64'd0);
    check("R10 flags", {32'd0, flags}, 64'd0);
    check("R10 err", {63'd0, err}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    runOp("R2 byte ilv low", 64'hFFEEDDCC_80FF0011, 64'h11223344_00AA8001, 1'b0, 2'd0, 2'd0);
    runOp("R1 byte ilv high", 64'hFFEEDDCC_80FF0011, 64'h11223344_00AA8001, 1'b1, 2'd0, 2'd0);
    runOp("R3 half ilv", 64'h0, 64'h8000_0000_1234_0000, 1'b0, 2'd1, 2'd0);
    runOp("R3 word ilv", 64'h0000_0000_8000_0001, 64'h0, 1'b0, 2'd2, 2'd0);
    runOp("R4 byte zero widen", 64'h0_80_7F_00_FF, 64'h0, 1'b0, 2'd0, 2'd1);
    runOp("R4 byte sign widen", 64'h0_80_7F_00_FF, 64'h0, 1'b0, 2'd0, 2'd2);
    runOp("R5 half sign widen", 64'hFFFF_8000_0000_0000, 64'h0, 1'b1, 2'd1, 2'd2);
    runOp("R5 word sign widen", 64'h8000_0000_0000_0000, 64'h0, 1'b1, 2'd2, 2'd2);
    runOp("R5 word zero widen", 64'h0, 64'hFFFF, 1'b0, 2'd2, 2'd1);
    holdCheck();
    runOp("R8 illegal size", 64'hDEAD_BEEF_0123_4567, 64'h1, 1'b0, 2'd3, 2'd0);
    holdCheck();
    runOp("R8 illegal mode", 64'hDEAD_BEEF_0123_4567, 64'h1, 1'b1, 2'd1, 2'd3);
    runOp("R8 err clears", 64'h5, 64'h6, 1'b0, 2'd0, 2'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      runOp("R1 R2 R3 R4 R5 random", {$urandom, $urandom}, {$urandom, $urandom},
            1'($urandom), 2'($urandom), 2'($urandom));
      if (i % 50 == 0) holdCheck();
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule